// File: doc/BRIEF.md
# Small-page NAND host command sequencer

This block sits between a host and one byte-wide NAND flash device with 528-byte pages. The host hands it one operation at a time over a valid/ready request port. The operation is one of five: page read, page program, block erase, status read or signature read. A request carries an area select, a column byte, a row address and a byte count.

The sequencer drives the device's chip enable, command latch, address latch, write and read strobes and the shared data bus. It issues the command, address and data cycles with strobe widths counted in system clocks, and it waits on the ready/busy line. Read bytes leave on a byte-wide output with a one-cycle valid pulse. Program bytes arrive on a byte-wide input with valid/ready.

After a program or erase, the sequencer reads the device status and reports failure from the status error bit. If the busy line stays low for too long, a watchdog ends the operation and raises a timeout flag. The number of address cycles is a parameter, so one design serves both the smallest density and the larger ones.

Top module: `nand_seq`

## Requirements
- R1: A page read opens with a pointer command chosen from `req_area`: 0 gives 8'h00, 1 gives 8'h01, and 2 or 3 gives 8'h50. This is followed by address cycles that carry the column byte first and then the row bytes, least significant first.
- R2: Page read and page program send `ADDR_CYCLES` address cycles. Erase sends `ADDR_CYCLES-1` address cycles, which carry only the row bytes. The row is `8*(ADDR_CYCLES-1)` bits wide.
- R3: After the last read address cycle, the read strobe stays high until ready/busy has been high, and at least `BUSY_SETTLE` cycles have passed. Then `req_len` bytes are read out, each given once on `rd_data` with a one-cycle `rd_valid`, in device order.
- R4: A program sends 8'h80, the address cycles, then `req_len` bytes taken in order from the `wr_valid`/`wr_ready` port, then 8'h10, and then it waits for ready/busy.
- R5: An erase sends 8'h60, the row address cycles and 8'hD0, and then it waits for ready/busy.
- R6: Once ready/busy has risen after a program or erase, the sequencer sends 8'h70 and reads one status byte. `fail` then equals bit 0 of that byte.
- R7: A status request (`req_op`=3) sends 8'h70 and passes the single byte it reads to `rd_data`.
- R8: A signature request (`req_op`=4) sends 8'h90, one address cycle of 8'h00, and then passes two bytes to `rd_data`: the maker code and then the device code.
- R9: If ready/busy stays low for `BUSY_LIMIT` cycles, the operation ends with `done`, `fail`=1 and `timeout`=1, and no status command is sent.
- R10: Each command, address or data write holds the write strobe low for exactly `WE_LOW` cycles. The latch enables and data stay steady while the strobe is low. The two latch enables are never high together, and the two strobes are never low together.
- R11: `req_ready` is high only while idle, and it drops in the cycle after a request is accepted. `done` is a one-cycle pulse. `fail` and `timeout` hold until the next request. Operation codes are: 0 read, 1 program, 2 erase, 3 status, 4 signature.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request taken |
| req_op | input | 3 | Operation code |
| req_area | input | 2 | Page area for read pointer |
| req_col | input | 8 | Column byte |
| req_row | input | 8*(ADDR_CYCLES-1) | Row address |
| req_len | input | clog2(PAGE_BYTES+1) | Bytes to read or program, 1 to PAGE_BYTES |
| wr_valid | input | 1 | Program byte offered |
| wr_ready | output | 1 | Program byte taken |
| wr_data | input | 8 | Program byte |
| rd_valid | output | 1 | Read byte pulse |
| rd_data | output | 8 | Read byte |
| done | output | 1 | Operation finished pulse |
| fail | output | 1 | Status error or timeout of last operation |
| timeout | output | 1 | Busy watchdog expired on last operation |
| nf_ce_n | output | 1 | Device chip enable, active low |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_dq_o | output | 8 | Bus value driven to device |
| nf_dq_oe | output | 1 | Bus drive enable |
| nf_dq_i | input | 8 | Bus value from device |
| nf_rb | input | 1 | Ready/busy, high when ready |

## Verification
The hardest case to reach is the busy watchdog. A correct device model always releases ready/busy, so the bench model takes a per-operation busy length. For one erase, that length is set past `BUSY_LIMIT`, which checks that no status command follows and that both flags are set. The model then releases ready/busy, and a status request checks that the sequencer recovers. A full 528-byte read covers the end-of-page count. A failing status byte on an erase checks the error path.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

    typedef enum logic [2:0] {
        OP_READ  = 3'd0,
        OP_PROG  = 3'd1,
        OP_ERASE = 3'd2,
        OP_STAT  = 3'd3,
        OP_SIG   = 3'd4
    } op_e;

    typedef enum logic [3:0] {
        S_IDLE, S_CMD, S_ADDR, S_FETCH, S_WDATA,
        S_CONF, S_BUSY, S_RDATA, S_SCMD, S_SREAD
    } state_e;

    localparam logic [7:0] C_PTR_LO  = 8'h00;
    localparam logic [7:0] C_PTR_HI  = 8'h01;
    localparam logic [7:0] C_PTR_SP  = 8'h50;
    localparam logic [7:0] C_PROG    = 8'h80;
    localparam logic [7:0] C_PROG_GO = 8'h10;
    localparam logic [7:0] C_ERASE   = 8'h60;
    localparam logic [7:0] C_ERA_GO  = 8'hD0;
    localparam logic [7:0] C_STATUS  = 8'h70;
    localparam logic [7:0] C_SIG     = 8'h90;

    function automatic logic [7:0] first_cmd(op_e op, logic [1:0] area);
        case (op)
            OP_READ:  return (area == 2'd0) ? C_PTR_LO :
                             (area == 2'd1) ? C_PTR_HI : C_PTR_SP;
            OP_PROG:  return C_PROG;
            OP_ERASE: return C_ERASE;
            OP_SIG:   return C_SIG;
            default:  return C_STATUS;
        endcase
    endfunction

endpackage

// File: rtl/nand_busy_timer.sv
module nand_busy_timer #(
    parameter int SETTLE = 3,
    parameter int LIMIT  = 20000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic rb,
    output logic ready,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (!run)                      cnt_d = '0;
        else if (cnt_q == CW'(LIMIT))  cnt_d = cnt_q;
        else                           cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign ready   = run && rb && (cnt_q >= CW'(SETTLE));
    assign expired = run && (cnt_q == CW'(LIMIT));

endmodule

// File: rtl/nand_seq.sv
module nand_seq
    import nand_seq_pkg::*;
#(
    parameter int ADDR_CYCLES = 3,
    parameter int PAGE_BYTES  = 528,
    parameter int WE_LOW      = 2,
    parameter int WE_HIGH     = 1,
    parameter int RE_LOW      = 2,
    parameter int RE_HIGH     = 1,
    parameter int BUSY_SETTLE = 3,
    parameter int BUSY_LIMIT  = 20000,
    localparam int ROW_W = 8 * (ADDR_CYCLES - 1),
    localparam int LEN_W = $clog2(PAGE_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [2:0]       req_op,
    input  logic [1:0]       req_area,
    input  logic [7:0]       req_col,
    input  logic [ROW_W-1:0] req_row,
    input  logic [LEN_W-1:0] req_len,
    input  logic             wr_valid,
    output logic             wr_ready,
    input  logic [7:0]       wr_data,
    output logic             rd_valid,
    output logic [7:0]       rd_data,
    output logic             done,
    output logic             fail,
    output logic             timeout,
    output logic             nf_ce_n,
    output logic             nf_cle,
    output logic             nf_ale,
    output logic             nf_we_n,
    output logic             nf_re_n,
    output logic [7:0]       nf_dq_o,
    output logic             nf_dq_oe,
    input  logic [7:0]       nf_dq_i,
    input  logic             nf_rb
);
    localparam int AW   = 8 * ADDR_CYCLES;
    localparam int MAXW = (WE_LOW > WE_HIGH ? WE_LOW : WE_HIGH);
    localparam int MAXR = (RE_LOW > RE_HIGH ? RE_LOW : RE_HIGH);
    localparam int TW   = $clog2((MAXW > MAXR ? MAXW : MAXR) + 1);

    typedef struct packed {
        state_e           st;
        op_e              op;
        logic [AW-1:0]    sh;
        logic [2:0]       acnt;
        logic [LEN_W-1:0] cnt;
        logic [TW-1:0]    tmr;
        logic             hi;
        logic             we_n;
        logic             re_n;
        logic             cle;
        logic             ale;
        logic             oe;
        logic [7:0]       dq;
        logic [7:0]       rdat;
        logic             rvld;
        logic             done;
        logic             fail;
        logic             tmo;
    } regs_t;

    localparam regs_t RST = '{st: S_IDLE, op: OP_STAT, we_n: 1'b1, re_n: 1'b1, default: '0};

    regs_t q, n;
    logic  bsy_run, bsy_ready, bsy_expired;

    function automatic regs_t wr_go(regs_t s, state_e st, logic c, logic a, logic [7:0] b);
        s.st = st; s.cle = c; s.ale = a; s.dq = b; s.oe = 1'b1;
        s.we_n = 1'b0; s.hi = 1'b0; s.tmr = TW'(WE_LOW - 1);
        return s;
    endfunction

    function automatic regs_t rd_go(regs_t s, state_e st);
        s.st = st; s.cle = 1'b0; s.ale = 1'b0; s.oe = 1'b0;
        s.re_n = 1'b0; s.hi = 1'b0; s.tmr = TW'(RE_LOW - 1);
        return s;
    endfunction

    nand_busy_timer #(.SETTLE(BUSY_SETTLE), .LIMIT(BUSY_LIMIT)) i_busy (
        .clk(clk), .rst_n(rst_n), .run(bsy_run), .rb(nf_rb),
        .ready(bsy_ready), .expired(bsy_expired)
    );

    assign bsy_run = (q.st == S_BUSY);

    always_comb begin
        op_e req_kind;
        logic wr_st, rd_st, edge_end;
        n      = q;
        n.rvld = 1'b0;
        n.done = 1'b0;
        req_kind = (req_op > 3'd4) ? OP_STAT : op_e'(req_op);
        wr_st  = (q.st inside {S_CMD, S_ADDR, S_WDATA, S_CONF, S_SCMD});
        rd_st  = (q.st inside {S_RDATA, S_SREAD});
        edge_end = (q.tmr == '0) && q.hi;

        if ((wr_st || rd_st) && q.tmr != '0) begin
            n.tmr = q.tmr - 1'b1;
        end else if (wr_st && !q.hi) begin
            n.we_n = 1'b1; n.hi = 1'b1; n.tmr = TW'(WE_HIGH - 1);
        end else if (rd_st && !q.hi) begin
            n.re_n = 1'b1; n.hi = 1'b1; n.tmr = TW'(RE_HIGH - 1);
            if (q.st == S_RDATA) begin n.rdat = nf_dq_i; n.rvld = 1'b1; end
            else                 n.fail = nf_dq_i[0];
        end

        case (q.st)
            S_IDLE: if (req_valid) begin
                n      = wr_go(n, S_CMD, 1'b1, 1'b0, first_cmd(req_kind, req_area));
                n.op   = req_kind;
                n.fail = 1'b0;
                n.tmo  = 1'b0;
                n.cnt  = (req_kind == OP_SIG) ? LEN_W'(2) :
                         (req_kind == OP_STAT) ? LEN_W'(1) : req_len;
                n.sh   = (req_kind == OP_ERASE) ? AW'(req_row) :
                         (req_kind == OP_SIG) ? '0 : {req_row, req_col};
                n.acnt = (req_kind == OP_ERASE) ? 3'(ADDR_CYCLES - 1) :
                         (req_kind == OP_SIG) ? 3'd1 :
                         (req_kind == OP_STAT) ? 3'd0 : 3'(ADDR_CYCLES);
            end
            S_CMD, S_ADDR: if (edge_end) begin
                if (q.acnt != 3'd0) begin
                    n      = wr_go(n, S_ADDR, 1'b0, 1'b1, q.sh[7:0]);
                    n.sh   = q.sh >> 8;
                    n.acnt = q.acnt - 1'b1;
                end else begin
                    case (q.op)
                        OP_READ:  begin n.st = S_BUSY; n.oe = 1'b0; n.ale = 1'b0; end
                        OP_PROG:  begin n.st = S_FETCH; n.ale = 1'b0; end
                        OP_ERASE: n = wr_go(n, S_CONF, 1'b1, 1'b0, C_ERA_GO);
                        default:  n = rd_go(n, S_RDATA);
                    endcase
                end
            end
            S_FETCH: if (wr_valid) n = wr_go(n, S_WDATA, 1'b0, 1'b0, wr_data);
            S_WDATA: if (edge_end) begin
                if (q.cnt == LEN_W'(1)) n = wr_go(n, S_CONF, 1'b1, 1'b0, C_PROG_GO);
                else begin n.st = S_FETCH; n.cnt = q.cnt - 1'b1; end
            end
            S_CONF: if (edge_end) begin n.st = S_BUSY; n.oe = 1'b0; n.cle = 1'b0; end
            S_BUSY: begin
                if (bsy_ready) begin
                    if (q.op == OP_READ) n = rd_go(n, S_RDATA);
                    else                 n = wr_go(n, S_SCMD, 1'b1, 1'b0, C_STATUS);
                end else if (bsy_expired) begin
                    n.st = S_IDLE; n.done = 1'b1; n.fail = 1'b1; n.tmo = 1'b1;
                end
            end
            S_SCMD: if (edge_end) n = rd_go(n, S_SREAD);
            S_RDATA: if (edge_end) begin
                if (q.cnt == LEN_W'(1)) begin n.st = S_IDLE; n.done = 1'b1; end
                else begin n = rd_go(n, S_RDATA); n.cnt = q.cnt - 1'b1; end
            end
            S_SREAD: if (edge_end) begin n.st = S_IDLE; n.done = 1'b1; end
            default: n = RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RST;
        else        q <= n;
    end

    assign req_ready = (q.st == S_IDLE);
    assign wr_ready  = (q.st == S_FETCH);
    assign rd_valid  = q.rvld;
    assign rd_data   = q.rdat;
    assign done      = q.done;
    assign fail      = q.fail;
    assign timeout   = q.tmo;
    assign nf_ce_n   = (q.st == S_IDLE);
    assign nf_cle    = q.cle;
    assign nf_ale    = q.ale;
    assign nf_we_n   = q.we_n;
    assign nf_re_n   = q.re_n;
    assign nf_dq_o   = q.dq;
    assign nf_dq_oe  = q.oe;

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nf_we_n && !nf_re_n)); // R10
    AST_LATCH_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(nf_cle && nf_ale)); // R10
    AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!nf_we_n && !$past(nf_we_n)) |-> ($stable(nf_dq_o) && $stable(nf_cle) && $stable(nf_ale))); // R10
    AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (bsy_run && !bsy_ready) |=> (nf_re_n && nf_we_n)); // R3
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11
    AST_READY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R11
    AST_TMO_NO_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout) |-> (req_ready && nf_we_n)); // R9

endmodule

// File: tb/test_nand_seq.sv
`timescale 1ns/1ps
module test_nand_seq;
    localparam int AC = 3;
    localparam int LIM = 100;
    localparam int WL = 2;
    localparam int ROW_W = 8 * (AC - 1);
    localparam int LEN_W = $clog2(528 + 1);

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_ready;
    logic [2:0] req_op = '0;
    logic [1:0] req_area = '0;
    logic [7:0] req_col = '0;
    logic [ROW_W-1:0] req_row = '0;
    logic [LEN_W-1:0] req_len = '0;
    logic wr_valid = 1'b1, wr_ready;
    logic [7:0] wr_data;
    logic rd_valid, done, fail, timeout;
    logic [7:0] rd_data;
    logic nf_ce_n, nf_cle, nf_ale, nf_we_n, nf_re_n, nf_dq_oe;
    logic [7:0] nf_dq_o;
    logic [7:0] nf_dq_i = '0;
    logic nf_rb = 1'b1;

    always #2.5 clk = ~clk;

    nand_seq #(.ADDR_CYCLES(AC), .WE_LOW(WL), .BUSY_LIMIT(LIM)) i_nand_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_area(req_area), .req_col(req_col), .req_row(req_row),
        .req_len(req_len), .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_data(rd_data), .done(done), .fail(fail),
        .timeout(timeout), .nf_ce_n(nf_ce_n), .nf_cle(nf_cle), .nf_ale(nf_ale),
        .nf_we_n(nf_we_n), .nf_re_n(nf_re_n), .nf_dq_o(nf_dq_o), .nf_dq_oe(nf_dq_oe),
        .nf_dq_i(nf_dq_i), .nf_rb(nf_rb)
    );

    int total = 0, failed = 0;
    logic [9:0] expq[$];
    logic [7:0] rdq[$];
    string cur_req = "R1";

    task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            failed++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    // program data source
    logic [7:0] wr_seed = 8'h00;
    int wr_idx = 0;
    always @(posedge clk) if (wr_valid && wr_ready) wr_idx <= wr_idx + 1;
    assign wr_data = wr_seed + 8'(wr_idx);

    // device model and monitor
    int busy_len = 10, busy = 0, wl = 0, k = 0, acount = 0, viol = 0;
    logic [7:0] last_cmd = 8'hFF, a0 = 0, a1 = 0, stat_byte = 8'hC0;
    logic prev_we = 1'b1, prev_re = 1'b1;

    always @(negedge clk) if (rst_n) begin
        if (!nf_we_n) wl++;
        if (!prev_we && nf_we_n) begin
            logic [9:0] got, e;
            got = {nf_cle, nf_ale, nf_dq_o};
            chk(wl == WL, "R10", "write strobe low width", wl, WL);
            if (expq.size() == 0) chk(0, cur_req, "unexpected bus write", got, 0);
            else begin
                e = expq.pop_front();
                chk(got == e, cur_req, "bus write {cle,ale,byte}", got, e);
            end
            if (nf_cle) begin
                last_cmd = nf_dq_o; acount = 0; k = 0;
                if (nf_dq_o == 8'h10 || nf_dq_o == 8'hD0) busy = busy_len;
            end else if (nf_ale) begin
                acount++;
                if (acount == 1) a0 = nf_dq_o;
                if (acount == 2) a1 = nf_dq_o;
                if ((last_cmd == 8'h00 || last_cmd == 8'h01 || last_cmd == 8'h50) && acount == AC)
                    busy = busy_len;
            end
            wl = 0;
        end
        prev_we = nf_we_n;
        if (prev_re && !nf_re_n) begin
            if (last_cmd == 8'h70) nf_dq_i = stat_byte;
            else if (last_cmd == 8'h90) nf_dq_i = (k == 0) ? 8'h20 : 8'h73;
            else nf_dq_i = (a0 ^ a1) + 8'(k);
            k++;
        end
        if (!nf_re_n && !nf_rb) viol++;
        prev_re = nf_re_n;
        if (busy > 0) busy--;
        nf_rb = (busy == 0);
        if (rd_valid) begin
            if (rdq.size() == 0) chk(0, cur_req, "unexpected read byte", rd_data, 0);
            else begin
                logic [7:0] e8;
                e8 = rdq.pop_front();
                chk(rd_data == e8, cur_req, "read byte", rd_data, e8);
            end
        end
    end

    task automatic run_op(input string rq, input int op, input int area, input logic [7:0] col,
                          input logic [ROW_W-1:0] row, input int len, input logic [7:0] sb,
                          input int blen, input bit exp_fail, input bit exp_tmo);
        logic [7:0] ptr;
        int n;
        cur_req = rq; stat_byte = sb; busy_len = blen;
        ptr = (area == 0) ? 8'h00 : (area == 1) ? 8'h01 : 8'h50;
        case (op)
            0: begin
                expq.push_back({2'b10, ptr});
                expq.push_back({2'b01, col});
                for (int i = 0; i < AC - 1; i++) expq.push_back({2'b01, row[8*i +: 8]});
                for (int i = 0; i < len; i++) rdq.push_back((col ^ row[7:0]) + 8'(i));
            end
            1: begin
                expq.push_back({2'b10, 8'h80});
                expq.push_back({2'b01, col});
                for (int i = 0; i < AC - 1; i++) expq.push_back({2'b01, row[8*i +: 8]});
                for (int i = 0; i < len; i++) expq.push_back({2'b00, wr_seed + 8'(wr_idx + i)});
                expq.push_back({2'b10, 8'h10});
                if (!exp_tmo) expq.push_back({2'b10, 8'h70});
            end
            2: begin
                expq.push_back({2'b10, 8'h60});
                for (int i = 0; i < AC - 1; i++) expq.push_back({2'b01, row[8*i +: 8]});
                expq.push_back({2'b10, 8'hD0});
                if (!exp_tmo) expq.push_back({2'b10, 8'h70});
            end
            3: begin
                expq.push_back({2'b10, 8'h70});
                rdq.push_back(sb);
            end
            default: begin
                expq.push_back({2'b10, 8'h90});
                expq.push_back({2'b01, 8'h00});
                rdq.push_back(8'h20); rdq.push_back(8'h73);
            end
        endcase
        viol = 0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R11", "req_ready while idle", req_ready, 1);
        req_op = 3'(op); req_area = 2'(area); req_col = col; req_row = row;
        req_len = LEN_W'(len); req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R11", "req_ready after accept", req_ready, 0);
        n = 0;
        while (!done && n < 20000) begin @(negedge clk); n++; end
        chk(done == 1'b1, rq, "done seen", done, 1);
        chk(fail == exp_fail, rq, "fail flag", fail, exp_fail);
        chk(timeout == exp_tmo, "R9", "timeout flag", timeout, exp_tmo);
        @(negedge clk);
        chk(done == 1'b0, "R11", "done single pulse", done, 0);
        chk(expq.size() == 0, rq, "bus writes left over", expq.size(), 0);
        chk(rdq.size() == 0, rq, "read bytes missing", rdq.size(), 0);
        chk(viol == 0, "R3", "read strobe while busy", viol, 0);
        expq.delete(); rdq.delete();
        while (!nf_rb) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "WDOG", "watchdog expired", 0, 1);
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R11", "reset req_ready", req_ready, 1);
        chk(nf_ce_n == 1'b1 && nf_we_n == 1'b1 && nf_re_n == 1'b1, "R10", "reset strobes idle",
            {nf_ce_n, nf_we_n, nf_re_n}, 3'b111);
        chk(done == 1'b0 && fail == 1'b0, "R11", "reset flags", {done, fail}, 0);
        run_op("R1", 0, 0, 8'h12, 16'h3456, 4, 8'hC0, 10, 0, 0);   // area 0, R2 three cycles
        run_op("R1", 0, 1, 8'h05, 16'h0102, 3, 8'hC0, 7, 0, 0);    // area 1
        run_op("R1", 0, 2, 8'h0A, 16'h00F0, 2, 8'hC0, 5, 0, 0);    // spare area
        run_op("R4", 1, 0, 8'h00, 16'h0042, 5, 8'hC0, 12, 0, 0);   // program, status pass R6
        run_op("R5", 2, 0, 8'h00, 16'h0180, 0, 8'hC1, 15, 1, 0);   // erase row only R2, status fail R6
        run_op("R7", 3, 0, 8'h00, 16'h0000, 0, 8'hE0, 0, 0, 0);
        run_op("R8", 4, 0, 8'h00, 16'h0000, 0, 8'hC0, 0, 0, 0);
        run_op("R3", 0, 0, 8'h00, 16'h0777, 528, 8'hC0, 20, 0, 0); // full page
        run_op("R9", 2, 0, 8'h00, 16'h0203, 0, 8'hC0, LIM + 50, 1, 1);
        run_op("R7", 3, 0, 8'h00, 16'h0000, 0, 8'h80, 0, 0, 0);    // recovery after timeout
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end
endmodule